// File: doc/BRIEF.md
# ASCII Decimal to Milli-Unit Fixed-Point Converter

This block takes a decimal number written as ASCII text, one character per clock, and turns it into a 32-bit two's complement integer. The integer equals the number times 1000. Fraction digits after the third are dropped, which truncates toward zero. A short fraction is padded with zeros, so "19.4" and "19.400" give the same result. The input may have an optional leading minus sign, an integer part, an optional decimal point and fraction digits. Spaces before and after the number are skipped.

A number is framed by two marker inputs. One flags the first character and the other flags the last. The converter keeps a running digit accumulator as characters arrive. At the last character it applies the zero padding, the range check and the sign in the same cycle. The result appears on the outputs with a one-cycle valid pulse in the following cycle. A malformed or out-of-range number raises the error flag and gives a value of zero.

Top module: `ascii_milli_conv`

## Requirements
- R1: While reset is held and after it, out_valid, out_value and out_error are all 0.
- R2: A character is accepted when in_valid is 1 and either in_first is 1 or a number is open. A character with in_first set starts a new number and discards any partial one. The number ends with the accepted character that has in_last set. out_valid is 1 for exactly the next cycle. Characters accepted while no number is open are ignored and produce no output.
- R3: A number with digits only ('0'..'9', codes 0x30..0x39) gives its value times 1000 ("42" gives 42000, "0" gives 0).
- R4: After one decimal point ('.', 0x2E), missing fraction digits count as zero ("19.4" gives 19400, ".5" gives 500, "5." gives 5000).
- R5: Fraction digits after the third are dropped, truncating toward zero ("4.7729" gives 4772, "1.999999" gives 1999, "-4.7729" gives -4772).
- R6: A minus sign ('-', 0x2D) is allowed only as the first non-space character and negates the result ("-11" gives -11000). A minus sign anywhere else is an error.
- R7: Spaces (0x20) before the first non-space character and after the last non-space character are ignored. A space between two non-space characters is an error.
- R8: Any other character, or a second decimal point, sets out_error to 1 and out_value to 0.
- R9: A number with no digit at all (for example "-", "." or only spaces) is an error.
- R10: The scaled result must lie in [-2147483648, 2147483647]; otherwise it is an error. A digit string so long that the accumulator would overflow is also an error.
- R11: Cycles with in_valid at 0 inside a number have no effect on the result.
- R12: out_value and out_error keep the last result until the next number completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_char holds a character this cycle |
| in_char | input | 8 | ASCII character |
| in_first | input | 1 | This character opens a number |
| in_last | input | 1 | This character closes a number |
| out_valid | output | 1 | One-cycle pulse: a result is on out_value/out_error |
| out_value | output | 32 | Value times 1000, two's complement, 0 on error |
| out_error | output | 1 | The last number was malformed or out of range |

## Verification
The assertions check four things on every cycle:
- an error result always carries the value zero;
- a result pulse is always caused by an accepted closing character;
- a number of one character always produces a pulse;
- the held outputs change only when a number closes.

The arithmetic itself can only be shown by the bench scenarios. These cover zero padding, truncation of extra fraction digits, sign handling, where spaces are legal, and both edges of the 32-bit range. The scenarios also show that idle cycles inside a number, characters outside any number, and a restart in the middle of a number leave the numeric result correct.

// File: rtl/ascii_milli_pkg.sv
// Shared types and helpers for the ASCII decimal to milli-unit converter.
// Assumes ASCII input; only digits, '-', '.' and space are meaningful.
package ascii_milli_pkg;

    // Classes of input character seen by the number accumulator
    typedef enum logic [2:0] {
        CLS_DIGIT,
        CLS_MINUS,
        CLS_POINT,
        CLS_SPACE,
        CLS_OTHER
    } char_cls_t;

    // Position inside a number: before it, inside it, after its trailing space
    typedef enum logic [1:0] {
        PH_LEAD,
        PH_BODY,
        PH_TAIL
    } num_phase_t;

    // Power of ten, for zero-padding short fractions
    function automatic logic [31:0] pow10(input int n);
        logic [31:0] r;
        r = 32'd1;
        for (int i = 0; i < n; i++) begin
            r = r * 32'd10;
        end
        return r;
    endfunction

endpackage

// File: rtl/milli_char_class.sv
// Character classifier: maps one ASCII byte to a character class.
// Purely combinational; assumes nothing about the surrounding framing.
module milli_char_class
    import ascii_milli_pkg::*;
(
    input  logic [7:0] ch,
    output char_cls_t  cls
);

    // Decode the byte into its class
    always_comb begin
        if (ch >= 8'h30 && ch <= 8'h39) begin
            cls = CLS_DIGIT;
        end else if (ch == 8'h2D) begin
            cls = CLS_MINUS;
        end else if (ch == 8'h2E) begin
            cls = CLS_POINT;
        end else if (ch == 8'h20) begin
            cls = CLS_SPACE;
        end else begin
            cls = CLS_OTHER;
        end
    end

endmodule

// File: rtl/milli_digit_accum.sv
// Digit accumulator: tracks framing, sign, decimal point, and a running
// magnitude acc*10+digit. At most FRAC_DIGITS fraction digits are kept.
// Assumes the digit value is valid whenever cls is CLS_DIGIT. On the closing
// character it presents the updated state with a one-cycle done strobe.
module milli_digit_accum
    import ascii_milli_pkg::*;
#(
    parameter int OUT_W       = 32,
    parameter int FRAC_DIGITS = 3,
    localparam int ACC_W      = OUT_W + 1,
    localparam int FCW        = $clog2(FRAC_DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  char_cls_t        cls,
    input  logic [3:0]       digit,
    output logic             done,
    output logic             fin_neg,
    output logic             fin_ndig,
    output logic             fin_ovf,
    output logic             fin_bad,
    output logic [FCW-1:0]   fin_fcnt,
    output logic [ACC_W-1:0] fin_acc
);

    localparam int GW = ACC_W + 4;
    localparam logic [GW-1:0] MAG_LIM = {{(GW-1){1'b0}}, 1'b1} << (OUT_W - 1);

    logic             open_q, neg_q, pt_q, ndig_q, ovf_q, bad_q;
    num_phase_t       phase_q;
    logic [FCW-1:0]   fcnt_q;
    logic [ACC_W-1:0] acc_q;

    logic             b_neg, b_pt, b_ndig, b_ovf, b_bad;
    num_phase_t       b_phase;
    logic [FCW-1:0]   b_fcnt;
    logic [ACC_W-1:0] b_acc;

    logic             n_neg, n_pt, n_ndig, n_ovf, n_bad;
    num_phase_t       n_phase;
    logic [FCW-1:0]   n_fcnt;
    logic [ACC_W-1:0] n_acc;

    logic [GW-1:0]    grow;
    logic             take;

    assign take = in_valid && (in_first || open_q);
    assign done = take && in_last;

    // Starting state: fresh for an opening character, else the held state
    always_comb begin
        if (in_first) begin
            b_neg = 1'b0; b_pt = 1'b0; b_ndig = 1'b0; b_ovf = 1'b0; b_bad = 1'b0;
            b_phase = PH_LEAD; b_fcnt = '0; b_acc = '0;
        end else begin
            b_neg = neg_q; b_pt = pt_q; b_ndig = ndig_q; b_ovf = ovf_q; b_bad = bad_q;
            b_phase = phase_q; b_fcnt = fcnt_q; b_acc = acc_q;
        end
    end

    // Candidate magnitude after appending one more digit
    always_comb begin
        grow = ({4'b0000, b_acc} << 3) + ({4'b0000, b_acc} << 1)
             + {{(GW-4){1'b0}}, digit};
    end

    // Apply one character to the starting state
    always_comb begin
        n_neg = b_neg; n_pt = b_pt; n_ndig = b_ndig; n_ovf = b_ovf; n_bad = b_bad;
        n_phase = b_phase; n_fcnt = b_fcnt; n_acc = b_acc;
        unique case (cls)
            CLS_SPACE: begin
                if (b_phase == PH_BODY) n_phase = PH_TAIL;
            end
            CLS_DIGIT: begin
                if (b_phase == PH_TAIL) begin
                    n_bad = 1'b1;
                end else begin
                    n_phase = PH_BODY;
                    n_ndig  = 1'b1;
                    if (!b_pt || b_fcnt < FCW'(FRAC_DIGITS)) begin
                        if (b_pt) n_fcnt = b_fcnt + FCW'(1);
                        if (!b_ovf) begin
                            if (grow > MAG_LIM) n_ovf = 1'b1;
                            else                n_acc = grow[ACC_W-1:0];
                        end
                    end
                end
            end
            CLS_MINUS: begin
                if (b_phase == PH_LEAD) begin
                    n_neg   = 1'b1;
                    n_phase = PH_BODY;
                end else begin
                    n_bad = 1'b1;
                end
            end
            CLS_POINT: begin
                if (b_phase == PH_TAIL || b_pt) begin
                    n_bad = 1'b1;
                end else begin
                    n_pt    = 1'b1;
                    n_phase = PH_BODY;
                end
            end
            default: n_bad = 1'b1;
        endcase
    end

    // Hold the per-number state between accepted characters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0; neg_q <= 1'b0; pt_q <= 1'b0; ndig_q <= 1'b0;
            ovf_q <= 1'b0; bad_q <= 1'b0; phase_q <= PH_LEAD;
            fcnt_q <= '0; acc_q <= '0;
        end else if (take) begin
            open_q <= !in_last;
            neg_q <= n_neg; pt_q <= n_pt; ndig_q <= n_ndig;
            ovf_q <= n_ovf; bad_q <= n_bad; phase_q <= n_phase;
            fcnt_q <= n_fcnt; acc_q <= n_acc;
        end
    end

    assign fin_neg  = n_neg;
    assign fin_ndig = n_ndig;
    assign fin_ovf  = n_ovf;
    assign fin_bad  = n_bad;
    assign fin_fcnt = n_fcnt;
    assign fin_acc  = n_acc;

endmodule

// File: rtl/milli_finalize.sv
// Result stage: pads missing fraction digits, checks the signed range,
// applies the sign and registers the result with a one-cycle valid pulse.
// Assumes fin_* inputs are meaningful only while done is 1.
module milli_finalize
    import ascii_milli_pkg::*;
#(
    parameter int OUT_W       = 32,
    parameter int FRAC_DIGITS = 3,
    localparam int ACC_W      = OUT_W + 1,
    localparam int FCW        = $clog2(FRAC_DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             fin_neg,
    input  logic             fin_ndig,
    input  logic             fin_ovf,
    input  logic             fin_bad,
    input  logic [FCW-1:0]   fin_fcnt,
    input  logic [ACC_W-1:0] fin_acc,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value,
    output logic             out_error
);

    localparam int PW = ACC_W + 4 * FRAC_DIGITS;
    localparam logic [PW-1:0] NEG_LIM = {{(PW-1){1'b0}}, 1'b1} << (OUT_W - 1);
    localparam logic [PW-1:0] POS_LIM = NEG_LIM - {{(PW-1){1'b0}}, 1'b1};

    logic [31:0]      scale;
    logic [PW-1:0]    mag;
    logic             fault;
    logic [OUT_W-1:0] value;

    // Pad the magnitude up to the full fraction width
    always_comb begin
        scale = pow10(FRAC_DIGITS - int'(fin_fcnt));
        mag   = PW'(fin_acc) * PW'(scale);
    end

    // Decide validity and form the signed result
    always_comb begin
        fault = fin_bad || fin_ovf || !fin_ndig
             || (fin_neg ? (mag > NEG_LIM) : (mag > POS_LIM));
        if (fault)        value = '0;
        else if (fin_neg) value = -mag[OUT_W-1:0];
        else              value = mag[OUT_W-1:0];
    end

    // Register the result and pulse valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_error <= 1'b0;
        end else begin
            out_valid <= done;
            if (done) begin
                out_value <= value;
                out_error <= fault;
            end
        end
    end

endmodule

// File: rtl/ascii_milli_conv.sv
// Top level: streamed ASCII decimal number to a two's complement integer
// scaled by 10^FRAC_DIGITS, truncating extra fraction digits.
// Assumes one character per cycle framed by in_first / in_last.
module ascii_milli_conv
    import ascii_milli_pkg::*;
#(
    parameter int OUT_W       = 32,
    parameter int FRAC_DIGITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_char,
    input  logic             in_first,
    input  logic             in_last,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value,
    output logic             out_error
);

    localparam int ACC_W = OUT_W + 1;
    localparam int FCW   = $clog2(FRAC_DIGITS + 1);

    char_cls_t        cls;
    logic             done, f_neg, f_ndig, f_ovf, f_bad;
    logic [FCW-1:0]   f_fcnt;
    logic [ACC_W-1:0] f_acc;

    milli_char_class u_class (
        .ch  (in_char),
        .cls (cls)
    );

    milli_digit_accum #(.OUT_W(OUT_W), .FRAC_DIGITS(FRAC_DIGITS)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_last  (in_last),
        .cls      (cls),
        .digit    (in_char[3:0]),
        .done     (done),
        .fin_neg  (f_neg),
        .fin_ndig (f_ndig),
        .fin_ovf  (f_ovf),
        .fin_bad  (f_bad),
        .fin_fcnt (f_fcnt),
        .fin_acc  (f_acc)
    );

    milli_finalize #(.OUT_W(OUT_W), .FRAC_DIGITS(FRAC_DIGITS)) u_final (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .fin_neg   (f_neg),
        .fin_ndig  (f_ndig),
        .fin_ovf   (f_ovf),
        .fin_bad   (f_bad),
        .fin_fcnt  (f_fcnt),
        .fin_acc   (f_acc),
        .out_valid (out_valid),
        .out_value (out_value),
        .out_error (out_error)
    );

endmodule

// File: rtl/ascii_milli_conv_chk.sv
// Port-level checker for ascii_milli_conv, attached with bind below.
module ascii_milli_conv_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_first,
    input logic             in_last,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_value,
    input logic             out_error
);

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_error) |-> (out_value == '0));

    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last));

    // R2
    single_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && in_last) |=> out_valid);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> ($stable(out_value) && $stable(out_error)));

endmodule

bind ascii_milli_conv ascii_milli_conv_chk #(.OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_value (out_value),
    .out_error (out_error)
);

// File: tb/ascii_milli_conv_tb_top.sv
module ascii_milli_conv_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_error;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    ascii_milli_conv dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_char   (in_char),
        .in_first  (in_first),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_value (out_value),
        .out_error (out_error)
    );

    typedef struct packed {
        logic [127:0] txt;
        logic [7:0]   len;
        logic [31:0]  val;
        logic         err;
        logic [15:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{"19.4",          8'd4,  32'd19400,       1'b0, "R4"},
        '{"4.7729",        8'd6,  32'd4772,        1'b0, "R5"},
        '{"-11",           8'd3,  -32'sd11000,     1'b0, "R6"},
        '{"42",            8'd2,  32'd42000,       1'b0, "R3"},
        '{"0",             8'd1,  32'd0,           1'b0, "R3"},
        '{".5",            8'd2,  32'd500,         1'b0, "R4"},
        '{"5.",            8'd2,  32'd5000,        1'b0, "R4"},
        '{"-4.7729",       8'd7,  -32'sd4772,      1'b0, "R5"},
        '{"-0.001",        8'd6,  -32'sd1,         1'b0, "R6"},
        '{"  12.5 ",       8'd7,  32'd12500,       1'b0, "R7"},
        '{"1 2",           8'd3,  32'd0,           1'b1, "R7"},
        '{"12a",           8'd3,  32'd0,           1'b1, "R8"},
        '{"1.2.3",         8'd5,  32'd0,           1'b1, "R8"},
        '{"5-",            8'd2,  32'd0,           1'b1, "R6"},
        '{"--5",           8'd3,  32'd0,           1'b1, "R6"},
        '{"-",             8'd1,  32'd0,           1'b1, "R9"},
        '{".",             8'd1,  32'd0,           1'b1, "R9"},
        '{"   ",           8'd3,  32'd0,           1'b1, "R9"},
        '{"2147483.647",   8'd11, 32'd2147483647,  1'b0, "R10"},
        '{"2147483.648",   8'd11, 32'd0,           1'b1, "R10"},
        '{"-2147483.648",  8'd12, 32'h8000_0000,   1'b0, "R10"},
        '{"-2147483.649",  8'd12, 32'd0,           1'b1, "R10"},
        '{"99999999999",   8'd11, 32'd0,           1'b1, "R10"},
        '{"000123.4567",   8'd11, 32'd123456,      1'b0, "R5"},
        '{"1.999999",      8'd8,  32'd1999,        1'b0, "R5"}
    };

    task automatic check(input logic ok, input string req,
                         input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got valid/err/value=%0b/%0b/%h expected %0b/%0b/%h",
                     req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic idle();
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_char = 8'h00;
    endtask

    // Send a framed number; gap inserts an idle cycle between characters.
    // Returns at the negedge where the result should be visible.
    task automatic send(input logic [127:0] txt, input int len, input bit gap);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_char  = txt[8*(len-1-i) +: 8];
            in_first = (i == 0);
            in_last  = (i == len - 1);
            if (gap && i < len - 1) begin
                @(negedge clk);
                idle();
            end
        end
        @(negedge clk);
        idle();
    endtask

    task automatic expect_result(input string req, input logic [31:0] val, input logic err);
        check(out_valid === 1'b1 && out_error === err && out_value === val, req,
              {out_valid, out_error, out_value}, {1'b1, err, val});
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        idle();
        // R1: outputs at reset
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_value === 32'd0 && out_error === 1'b0, "R1",
              {out_valid, out_error, out_value}, 34'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_value === 32'd0 && out_error === 1'b0, "R1",
              {out_valid, out_error, out_value}, 34'd0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            send(VECS[k].txt, int'(VECS[k].len), 1'b0);
            expect_result(string'(VECS[k].req), VECS[k].val, VECS[k].err);
        end

        // R2: single-character number
        send("7", 1, 1'b0);
        expect_result("R2", 32'd7000, 1'b0);

        // R12: outputs hold, valid drops
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_value === 32'd7000 && out_error === 1'b0, "R12",
              {out_valid, out_error, out_value}, {1'b0, 1'b0, 32'd7000});

        // R11: idle cycles between characters
        send("-12.75", 6, 1'b1);
        expect_result("R11", -32'sd12750, 1'b0);

        // R2: characters with no open number are ignored, even with in_last
        held = out_value;
        @(negedge clk); in_valid = 1'b1; in_char = "9";
        @(negedge clk); in_char = "x"; in_last = 1'b1;
        @(negedge clk); idle();
        check(out_valid === 1'b0 && out_value === held && out_error === 1'b0, "R2",
              {out_valid, out_error, out_value}, {1'b0, 1'b0, held});

        // R2: restart mid-number discards the partial (and bad) state
        @(negedge clk); in_valid = 1'b1; in_first = 1'b1; in_char = "x";
        @(negedge clk); in_first = 1'b0; in_char = "8";
        @(negedge clk); in_first = 1'b1; in_last = 1'b1; in_char = "3";
        @(negedge clk); idle();
        expect_result("R2", 32'd3000, 1'b0);

        // R8 after a good result: error forces value to zero
        send("1x", 2, 1'b0);
        expect_result("R8", 32'd0, 1'b1);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule